// File: doc/BRIEF.md
# Two-Source Binary Tree Destination Switch

This block joins two requesting sources to a set of destination ports through a tree of 2x2 interchange switches. A single root switch takes both sources. Each level below it steers a request by one bit of its destination number, starting with the most significant bit. With the default depth of three levels there are eight ports, numbered 0 to 7. A source raises its valid flag and presents a destination number and a data word. In that same cycle the block returns a grant if the path can be built. Because both sources pass through the one root switch, two paths can coexist only when their destination MSBs differ.

A granted path is then held for as long as the source keeps its valid high. During that time the destination input of that source is ignored, and the source's data word is forwarded to the selected port every cycle. The port reports one cycle later, on registered outputs, and also reports which source owns it. When two requests compete for the same root output, the path that is already held keeps it. If neither path is held, source 0 wins. A blocked source is not queued. It is granted only once it still presents a request that can be routed.

Top module: `bts_tree_switch`

## Requirements
- R1: After a synchronous reset, every `dst_valid` bit is low and no path is held, so a lone request in the first cycle after reset is granted at once.
- R2: A lone valid source gets `src_gnt` high in the same cycle. On the next cycle, port number N, where N is its destination value (MSB picks the root output, the next bit the second level, the LSB the last level), shows `dst_valid` high, `dst_src` equal to the source index (0 or 1) and `dst_data` equal to the word the source presented. Every other port shows `dst_valid` low.
- R3: Two requests whose destination MSBs differ are both granted in the same cycle, and both of their ports are driven on the next cycle.
- R4: Two new requests, neither one held, whose destination MSBs are equal: source 0 is granted, and source 1 sees `src_gnt[1]` low in that same cycle. This also applies when both name the same destination.
- R5: A held path is never preempted. A new request whose MSB equals the MSB of a held path is blocked, whichever source holds the path.
- R6: While a path is held and the source keeps valid high, changes on that source's destination input have no effect: the same port stays driven. The port's data follows the source's data input with one cycle of delay.
- R7: A held path is released at the clock edge at which its source's valid is low. Its port shows `dst_valid` low from the next cycle on. During the cycle in which valid is low, the path still blocks a conflicting request. That request, if still valid, is granted in the following cycle.
- R8: `src_gnt` is low whenever the corresponding `src_valid` is low. A blocked request leaves no state behind: if it is withdrawn, no port is ever driven on its behalf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 2 | Request/hold flag per source, bit i for source i |
| src_dest | input | 2*LVL | Destination number per source, source i in bits [i*LVL +: LVL] |
| src_data | input | 2*DW | Data word per source, source i in bits [i*DW +: DW] |
| src_gnt | output | 2 | Same-cycle grant per source |
| dst_valid | output | 2**LVL | Registered port-active flag per destination |
| dst_src | output | 2**LVL | Registered owning source per destination (0 or 1) |
| dst_data | output | 2**LVL*DW | Registered data per destination, port d in bits [d*DW +: DW] |

## Verification
The bench uses the defaults LVL=3 and DW=8, which gives eight ports and three steering levels. At this size the bench can sweep every destination for each source alone. It can also try every pairing of root halves and every same-half contest, in both held and fresh orders. A pseudo-random phase then mixes fresh requests, holds with a changing destination input, and releases. This reaches the cases where a release and a blocked retry fall in adjacent cycles.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } src_id_e;
endpackage

// File: rtl/bts_xchg.sv
// Root 2x2 interchange cell: decides which of two requests gets its output half.
module bts_xchg (
  input  logic clk,
  input  logic rst,
  input  logic a_req,
  input  logic a_lock,
  input  logic a_bit,
  input  logic b_req,
  input  logic b_lock,
  input  logic b_bit,
  output logic a_ok,
  output logic b_ok
);
  logic same_half;

  always_comb begin
    same_half = (a_bit == b_bit);
    // A held path keeps its half; otherwise input A has priority.
    a_ok = a_req && (a_lock || !(same_half && b_lock));
    b_ok = b_req && (b_lock || !(same_half && (a_lock || a_req)));
  end

  p_first_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (a_req && b_req && !a_lock && !b_lock && (a_bit == b_bit)) |-> (a_ok && !b_ok));

  p_no_preempt_a_r5: assert property (@(posedge clk) disable iff (rst)
    (a_lock && a_req) |-> a_ok);

  p_no_preempt_b_r5: assert property (@(posedge clk) disable iff (rst)
    (b_lock && b_req) |-> b_ok);

  p_split_halves_r3: assert property (@(posedge clk) disable iff (rst)
    (a_ok && b_ok) |-> (a_bit != b_bit));
endmodule

// File: rtl/bts_path_hold.sv
// Per-source path state: holds the destination while the grant persists.
module bts_path_hold #(
  parameter int LVL = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [LVL-1:0] req_dest,
  input  logic           grant,
  output logic           held,
  output logic [LVL-1:0] eff_dest
);
  logic [LVL-1:0] hold_dest;

  always_ff @(posedge clk) begin
    if (rst) begin
      held      <= 1'b0;
      hold_dest <= '0;
    end else begin
      held <= grant;
      if (grant && !held) hold_dest <= req_dest;
    end
  end

  assign eff_dest = held ? hold_dest : req_dest;

  p_dest_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (held && grant) |=> (hold_dest == $past(hold_dest)));

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (held && !req_valid) |=> !held);

  p_grant_needs_valid_r8: assert property (@(posedge clk) disable iff (rst)
    grant |-> req_valid);
endmodule

// File: rtl/bts_route.sv
// Steers one request down the tree, one destination bit per level, MSB first.
module bts_route #(
  parameter int LVL  = 3,
  localparam int NDST = 1 << LVL
) (
  input  logic           en,
  input  logic [LVL-1:0] dest,
  output logic [NDST-1:0] port_sel
);
  logic [NDST-1:0] mask;
  logic [NDST-1:0] nxt;

  always_comb begin
    mask    = '0;
    mask[0] = en;
    nxt     = '0;
    for (int l = 0; l < LVL; l++) begin
      nxt = '0;
      for (int k = 0; k < NDST / 2; k++) begin
        nxt[2*k]   = mask[k] & ~dest[LVL-1-l];
        nxt[2*k+1] = mask[k] &  dest[LVL-1-l];
      end
      mask = nxt;
    end
    port_sel = mask;
  end
endmodule

// File: rtl/bts_port_bank.sv
// Registered destination ports fed by the two routed selections.
module bts_port_bank
  import bts_pkg::*;
#(
  parameter int LVL = 3,
  parameter int DW  = 8,
  localparam int NDST = 1 << LVL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NDST-1:0]   sel_a,
  input  logic [NDST-1:0]   sel_b,
  input  logic [DW-1:0]     data_a,
  input  logic [DW-1:0]     data_b,
  output logic [NDST-1:0]   dst_valid,
  output logic [NDST-1:0]   dst_src,
  output logic [NDST*DW-1:0] dst_data
);
  for (genvar d = 0; d < NDST; d++) begin : g_port
    src_id_e owner;
    assign owner = sel_b[d] ? SRC_B : SRC_A;

    always_ff @(posedge clk) begin
      if (rst) begin
        dst_valid[d]          <= 1'b0;
        dst_src[d]            <= 1'b0;
        dst_data[d*DW +: DW]  <= '0;
      end else begin
        dst_valid[d]          <= sel_a[d] | sel_b[d];
        dst_src[d]            <= owner;
        dst_data[d*DW +: DW]  <= (owner == SRC_B) ? data_b : data_a;
      end
    end

    p_single_owner_r3: assert property (@(posedge clk) disable iff (rst)
      !(sel_a[d] && sel_b[d]));
  end
endmodule

// File: rtl/bts_tree_switch.sv
module bts_tree_switch #(
  parameter int LVL = 3,
  parameter int DW  = 8,
  localparam int NDST = 1 << LVL
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         src_valid,
  input  logic [2*LVL-1:0]   src_dest,
  input  logic [2*DW-1:0]    src_data,
  output logic [1:0]         src_gnt,
  output logic [NDST-1:0]    dst_valid,
  output logic [NDST-1:0]    dst_src,
  output logic [NDST*DW-1:0] dst_data
);
  logic [1:0]      held;
  logic [LVL-1:0]  eff_dest [2];
  logic [NDST-1:0] port_sel [2];

  for (genvar s = 0; s < 2; s++) begin : g_src
    bts_path_hold #(.LVL(LVL)) u_hold (
      .clk      (clk),
      .rst      (rst),
      .req_valid(src_valid[s]),
      .req_dest (src_dest[s*LVL +: LVL]),
      .grant    (src_gnt[s]),
      .held     (held[s]),
      .eff_dest (eff_dest[s])
    );

    bts_route #(.LVL(LVL)) u_route (
      .en      (src_gnt[s]),
      .dest    (eff_dest[s]),
      .port_sel(port_sel[s])
    );
  end

  bts_xchg u_root (
    .clk   (clk),
    .rst   (rst),
    .a_req (src_valid[0]),
    .a_lock(held[0]),
    .a_bit (eff_dest[0][LVL-1]),
    .b_req (src_valid[1]),
    .b_lock(held[1]),
    .b_bit (eff_dest[1][LVL-1]),
    .a_ok  (src_gnt[0]),
    .b_ok  (src_gnt[1])
  );

  bts_port_bank #(.LVL(LVL), .DW(DW)) u_ports (
    .clk      (clk),
    .rst      (rst),
    .sel_a    (port_sel[0]),
    .sel_b    (port_sel[1]),
    .data_a   (src_data[0 +: DW]),
    .data_b   (src_data[DW +: DW]),
    .dst_valid(dst_valid),
    .dst_src  (dst_src),
    .dst_data (dst_data)
  );

  p_port_count_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(dst_valid) == $countones($past(src_gnt))));
endmodule

// File: tb/bts_tree_switch_tb_top.sv
module bts_tree_switch_tb_top;
  localparam int LVL  = 3;
  localparam int DW   = 8;
  localparam int NDST = 1 << LVL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]         src_valid;
  logic [2*LVL-1:0]   src_dest;
  logic [2*DW-1:0]    src_data;
  logic [1:0]         src_gnt;
  logic [NDST-1:0]    dst_valid;
  logic [NDST-1:0]    dst_src;
  logic [NDST*DW-1:0] dst_data;

  logic           v  [2];
  logic [LVL-1:0] dd [2];
  logic [DW-1:0]  dt [2];

  assign src_valid = {v[1], v[0]};
  assign src_dest  = {dd[1], dd[0]};
  assign src_data  = {dt[1], dt[0]};

  always #5 clk = ~clk;

  bts_tree_switch #(.LVL(LVL), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_dest(src_dest),
    .src_data(src_data), .src_gnt(src_gnt), .dst_valid(dst_valid),
    .dst_src(dst_src), .dst_data(dst_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // Reference state
  int m_hold [2];
  int m_hdst [2];
  int e_v [NDST];
  int e_s [NDST];
  int e_d [NDST];

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  // One clock: compare gnt and ports mid-cycle, then advance the model.
  task automatic tick(string tag);
    int msb [2];
    int g [2];
    int port;
    #3;
    for (int i = 0; i < 2; i++) begin
      dt[i] = DW'((cyc * 7 + i * 91 + 3) & 255);
      msb[i] = (m_hold[i] != 0) ? (m_hdst[i] >> (LVL - 1)) : (int'(dd[i]) >> (LVL - 1));
    end
    #1;
    // source 0
    if (!v[0]) g[0] = 0;
    else if (m_hold[0] != 0) g[0] = 1;
    else if (m_hold[1] != 0 && msb[1] == msb[0]) g[0] = 0;
    else g[0] = 1;
    // source 1
    if (!v[1]) g[1] = 0;
    else if (m_hold[1] != 0) g[1] = 1;
    else if (m_hold[0] != 0 && msb[0] == msb[1]) g[1] = 0;
    else if (v[0] && msb[0] == msb[1]) g[1] = 0;
    else g[1] = 1;

    chk(tag, "gnt0", int'(src_gnt[0]), g[0]);
    chk(tag, "gnt1", int'(src_gnt[1]), g[1]);
    for (int d = 0; d < NDST; d++) begin
      chk(tag, $sformatf("port%0d valid", d), int'(dst_valid[d]), e_v[d]);
      if (e_v[d] != 0) begin
        chk(tag, $sformatf("port%0d src", d), int'(dst_src[d]), e_s[d]);
        chk(tag, $sformatf("port%0d data", d), int'(dst_data[d*DW +: DW]), e_d[d]);
      end
    end
    for (int d = 0; d < NDST; d++) e_v[d] = 0;
    for (int i = 0; i < 2; i++) begin
      if (g[i] != 0) begin
        port = (m_hold[i] != 0) ? m_hdst[i] : int'(dd[i]);
        e_v[port] = 1;
        e_s[port] = i;
        e_d[port] = int'(dt[i]);
        if (m_hold[i] == 0) m_hdst[i] = int'(dd[i]);
      end
      m_hold[i] = g[i];
    end
    @(posedge clk);
    #1;
    cyc++;
  endtask

  task automatic drive(bit a_v, int a_d, bit b_v, int b_d);
    v[0] = a_v; dd[0] = LVL'(a_d);
    v[1] = b_v; dd[1] = LVL'(b_d);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 2; i++) begin
      m_hold[i] = 0; m_hdst[i] = 0; dt[i] = '0;
    end
    for (int d = 0; d < NDST; d++) begin
      e_v[d] = 0; e_s[d] = 0; e_d[d] = 0;
    end
    drive(0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;

    // R1: idle after reset, then immediate grant in first active cycle
    tick("R1");
    drive(1, 6, 0, 0); tick("R1");
    drive(0, 0, 0, 0); tick("R1"); tick("R1");

    // R2: each source alone to every destination
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < NDST; d++) begin
        if (s == 0) drive(1, d, 0, 0); else drive(0, 0, 1, d);
        tick("R2"); tick("R2");
        drive(0, 0, 0, 0); tick("R2");
      end
    end
    tick("R2");

    // R3: differing MSBs, both granted
    drive(1, 1, 1, 6); tick("R3"); tick("R3");
    drive(0, 0, 0, 0); tick("R3");
    drive(1, 7, 1, 0); tick("R3"); tick("R3");
    drive(0, 0, 0, 0); tick("R3"); tick("R3");

    // R4: same MSB, fresh contest; also identical destination
    drive(1, 3, 1, 2); tick("R4"); tick("R4");
    drive(0, 0, 0, 0); tick("R4");
    drive(1, 4, 1, 4); tick("R4");
    drive(0, 0, 0, 0); tick("R4"); tick("R4");

    // R5: source 1 holds, source 0 blocked
    drive(0, 0, 1, 6); tick("R5");
    drive(1, 5, 1, 6); tick("R5"); tick("R5");
    // R7: holder drops; blocked source still waits this cycle, then wins
    drive(1, 5, 0, 6); tick("R7"); tick("R7"); tick("R7");
    // R5: source 0 holds now, source 1 blocked
    drive(1, 5, 1, 4); tick("R5"); tick("R5");
    // R6: destination input of holder changes; ignored
    drive(1, 2, 1, 4); tick("R6"); tick("R6");
    drive(1, 7, 1, 4); tick("R6");
    // R8: blocked source withdraws, leaves no trace
    drive(1, 7, 0, 4); tick("R8"); tick("R8");
    drive(0, 7, 0, 4); tick("R8"); tick("R8"); tick("R8");
    // R7: drop one cycle then reacquire at a new destination
    drive(1, 1, 0, 0); tick("R7"); tick("R7");
    drive(0, 1, 0, 0); tick("R7");
    drive(1, 6, 0, 0); tick("R7"); tick("R7");
    drive(0, 0, 0, 0); tick("R7"); tick("R7");

    // Mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0] | lfsr[1], int'(lfsr[6:4]), lfsr[2] | lfsr[3], int'(lfsr[10:8]));
      tick("R5");
    end
    drive(0, 0, 0, 0); tick("R8"); tick("R8");

    done = 1'b1;
    finish_run();
  end
endmodule